// File: doc/BRIEF.md
# SDRAM Initialization and Refresh Sequencer

This block drives the command pins and clock enable of a single-rank SDR SDRAM through its whole maintenance life. After reset it runs the power-up sequence: a long quiet pause, one all-bank precharge, a burst of auto refreshes, and a mode register load. From then on it issues periodic auto refreshes, takes the device into self refresh when asked, and brings it back out. An external read/write engine shares the command bus. The sequencer grants it the bus while idle. When maintenance is due, the sequencer withdraws the grant and waits for the engine to report that it is no longer busy.

Every delay is a parameter counted in clock cycles. A refresh-age tracker counts the cycles since the last refresh. If the engine holds the bus past the allowed refresh period, the next maintenance slot issues two refreshes back to back instead of one. On a self-refresh exit, CKE is raised first. The sequencer then keeps the bus quiet for two cycles plus one row-cycle time before it reports ready again.

The sequencer's command outputs are decoded directly from its state register. The engine's commands are multiplexed onto the pins outside this block while `bus_grant_o` is high. Reset is asynchronous and active low, and it must be released in step with the clock. Parameters must satisfy `T_RP_CYC`, `T_RC_CYC`, `T_MRD_CYC` >= 2, `T_REF_MAX_CYC` >= `T_REFI_CYC`, `T_PWRUP_CYC` >= `T_RC_CYC` + 2, and `ADDR_W` >= 11.

Top module: `sdr_refresh_seq`

## Requirements
- R1: For the first `T_PWRUP_CYC` cycles after reset (cycles 0 to `T_PWRUP_CYC`-1), the pins carry NOP (CS#,RAS#,CAS#,WE# = 0111) with CKE high, and `ready_o` and `bus_grant_o` are low.
- R2: In cycle `T_PWRUP_CYC` the first command other than NOP appears: precharge (0010) with address bit 10 high and every other address bit low.
- R3: Exactly `N_INIT_REF` auto refreshes (0001, CKE high, address zero) follow. The first comes `T_RP_CYC` cycles after the precharge and the others are spaced `T_RC_CYC` cycles apart. The mode register load (0000) comes `T_RC_CYC` cycles after the last of them and never earlier.
- R4: The mode register load drives address bits [2:0] with `MR_BURST_LEN`, bit 3 with `MR_BURST_SEQ`, bits [6:4] with `MR_CAS_LAT`, and zero above. `ready_o` and `bus_grant_o` rise exactly `T_MRD_CYC` cycles after the load.
- R5: With the bus free, each periodic refresh comes `T_REFI_CYC`+2 cycles after the previous refresh. `ready_o` and `bus_grant_o` are low in the refresh cycle and for the following `T_RC_CYC`-1 cycles.
- R6: Once a refresh or self-refresh entry is pending, `bus_grant_o` drops the next cycle. No command other than NOP is issued while `bus_busy_i` is high or while `bus_grant_o` is high. The pending refresh is issued the cycle after `bus_busy_i` is first seen low.
- R7: If more than `T_REF_MAX_CYC` cycles have passed since the last refresh when a refresh is issued, a second refresh follows `T_RC_CYC` cycles later. `ready_o` is reasserted only `T_RC_CYC` cycles after the second one.
- R8: A self-refresh request, once the bus is free, produces the refresh encoding (0001) with CKE low in the same cycle. CKE stays low while `sref_req_i` stays high.
- R9: When `sref_req_i` falls during self refresh, CKE goes high the next cycle. Only NOP follows for 2+`T_RC_CYC` cycles, counted from the first cycle with CKE high, after which `ready_o` returns. The refresh age restarts at that first cycle.
- R10: When a periodic refresh and a self-refresh request are both pending as the bus frees, the refresh is issued first and the self-refresh entry follows once it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| sref_req_i | input | 1 | Level request to enter and stay in self refresh |
| bus_busy_i | input | 1 | External engine still owns the command bus |
| bus_grant_o | output | 1 | External engine may issue commands |
| ready_o | output | 1 | Device initialized and not under maintenance |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_cke_o | output | 1 | Clock enable |
| sd_addr_o | output | ADDR_W | Address pins (A10 and mode word) |

## Verification
Periodic refresh is tried with a free bus, which fixes the baseline interval. It is also tried with the engine busy for a short hold, where a single refresh must follow the release, and for a hold past the refresh limit, where the doubled refresh must appear. Self refresh is entered from idle and again with a refresh pending at the same moment. This checks the refresh-first priority, the held-low CKE, and the exact quiet window after exit. The refresh that follows the exit shows that the age count restarts.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // Pin encoding order: {CS#, RAS#, CAS#, WE#}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_PREA,
    ST_PREA_W,
    ST_IREF,
    ST_IREF_W,
    ST_MRS,
    ST_MRS_W,
    ST_IDLE,
    ST_DRAIN,
    ST_REF,
    ST_REF_W,
    ST_SRE,
    ST_SELF,
    ST_SRX,
    ST_SRX_W
  } seq_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_seq_timer.sv
module sdr_seq_timer #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= RST_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sdr_seq_age.sv
module sdr_seq_age #(
  parameter int T_REFI_CYC    = 1560,
  parameter int T_REF_MAX_CYC = 3120
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic refresh_i,
  input  logic sleep_i,
  output logic due_o,
  output logic overrun_o
);

  localparam int           AW       = $clog2(T_REF_MAX_CYC + 2);
  localparam logic [AW-1:0] AGE_SAT = AW'(T_REF_MAX_CYC + 1);
  localparam logic [AW-1:0] AGE_DUE = AW'(T_REFI_CYC);
  localparam logic [AW-1:0] AGE_MAX = AW'(T_REF_MAX_CYC);

  logic [AW-1:0] age_q;
  logic [AW-1:0] age_d;
  logic          age_en;

  always_comb begin
    age_en = sleep_i | refresh_i | (age_q != AGE_SAT);
    if (sleep_i) begin
      age_d = '0;
    end else if (refresh_i) begin
      age_d = AW'(1);
    end else begin
      age_d = age_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      age_q <= '0;
    end else if (age_en) begin
      age_q <= age_d;
    end
  end

  assign due_o     = (age_q >= AGE_DUE);
  assign overrun_o = (age_q > AGE_MAX);

endmodule

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
#(
  parameter int         T_RP_CYC     = 4,
  parameter int         T_RC_CYC     = 13,
  parameter int         T_MRD_CYC    = 2,
  parameter int         N_INIT_REF   = 8,
  parameter int         ADDR_W       = 13,
  parameter int         TW           = 15,
  parameter logic [2:0] MR_BURST_LEN = 3'b011,
  parameter logic       MR_BURST_SEQ = 1'b0,
  parameter logic [2:0] MR_CAS_LAT   = 3'd3
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              tmr_done_i,
  input  logic              due_i,
  input  logic              overrun_i,
  input  logic              busy_i,
  input  logic              sref_req_i,
  output logic              tmr_load_o,
  output logic [TW-1:0]     tmr_val_o,
  output logic              refresh_o,
  output sdr_cmd_e          cmd_o,
  output logic              cke_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o,
  output logic              grant_o
);

  localparam int RLW = $clog2(max_of(N_INIT_REF, 2) + 1);

  localparam logic [TW-1:0] LD_RP  = TW'(T_RP_CYC - 2);
  localparam logic [TW-1:0] LD_RC  = TW'(T_RC_CYC - 2);
  localparam logic [TW-1:0] LD_MRD = TW'(T_MRD_CYC - 2);
  localparam logic [TW-1:0] LD_SRX = TW'(1);
  localparam logic [TW-1:0] LD_SRW = TW'(T_RC_CYC - 1);

  localparam logic [ADDR_W-1:0] PREA_WORD = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'({MR_CAS_LAT, MR_BURST_SEQ, MR_BURST_LEN});

  seq_state_e     state_q;
  seq_state_e     state_d;
  logic [RLW-1:0] rl_q;
  logic [RLW-1:0] rl_d;
  logic           rl_en;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    rl_d    = rl_q;
    rl_en   = 1'b0;
    case (state_q)
      ST_PWRUP:  if (tmr_done_i) state_d = ST_PREA;
      ST_PREA: begin
        state_d = ST_PREA_W;
        rl_d    = RLW'(N_INIT_REF);
        rl_en   = 1'b1;
      end
      ST_PREA_W: if (tmr_done_i) state_d = ST_IREF;
      ST_IREF: begin
        state_d = ST_IREF_W;
        rl_d    = rl_q - 1'b1;
        rl_en   = 1'b1;
      end
      ST_IREF_W: if (tmr_done_i) state_d = (rl_q == '0) ? ST_MRS : ST_IREF;
      ST_MRS:    state_d = ST_MRS_W;
      ST_MRS_W:  if (tmr_done_i) state_d = ST_IDLE;
      ST_IDLE:   if (due_i || sref_req_i) state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (!busy_i) begin
          if (due_i) begin
            state_d = ST_REF;
            rl_d    = overrun_i ? RLW'(2) : RLW'(1);
            rl_en   = 1'b1;
          end else if (sref_req_i) begin
            state_d = ST_SRE;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_REF: begin
        state_d = ST_REF_W;
        rl_d    = rl_q - 1'b1;
        rl_en   = 1'b1;
      end
      ST_REF_W:  if (tmr_done_i) state_d = (rl_q == '0) ? ST_IDLE : ST_REF;
      ST_SRE:    state_d = ST_SELF;
      ST_SELF:   if (!sref_req_i) state_d = ST_SRX;
      ST_SRX:    if (tmr_done_i) state_d = ST_SRX_W;
      ST_SRX_W:  if (tmr_done_i) state_d = ST_IDLE;
      default:   state_d = ST_PWRUP;
    endcase
  end

  // Timer load on every state change, value picks the new state's length
  always_comb begin
    tmr_load_o = (state_d != state_q);
    case (state_d)
      ST_PREA_W:          tmr_val_o = LD_RP;
      ST_IREF_W, ST_REF_W: tmr_val_o = LD_RC;
      ST_MRS_W:           tmr_val_o = LD_MRD;
      ST_SRX:             tmr_val_o = LD_SRX;
      ST_SRX_W:           tmr_val_o = LD_SRW;
      default:            tmr_val_o = '0;
    endcase
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_PWRUP;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rl_q <= '0;
    end else if (rl_en) begin
      rl_q <= rl_d;
    end
  end

  // Output decode from the state register
  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    case (state_q)
      ST_PREA: begin
        cmd_o  = CMD_PRE;
        addr_o = PREA_WORD;
      end
      ST_IREF, ST_REF, ST_SRE: cmd_o = CMD_REF;
      ST_MRS: begin
        cmd_o  = CMD_MRS;
        addr_o = MODE_WORD;
      end
      default: cmd_o = CMD_NOP;
    endcase
  end

  assign cke_o     = !((state_q == ST_SRE) || (state_q == ST_SELF));
  assign refresh_o = (state_q == ST_IREF) || (state_q == ST_REF);
  assign ready_o   = (state_q == ST_IDLE) || (state_q == ST_DRAIN);
  assign grant_o   = (state_q == ST_IDLE);

endmodule

// File: rtl/sdr_refresh_seq.sv
module sdr_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int         T_PWRUP_CYC   = 20000,
  parameter int         T_RP_CYC      = 4,
  parameter int         T_RC_CYC      = 13,
  parameter int         T_MRD_CYC     = 2,
  parameter int         T_REFI_CYC    = 1560,
  parameter int         T_REF_MAX_CYC = 3120,
  parameter int         N_INIT_REF    = 8,
  parameter int         ADDR_W        = 13,
  parameter logic [2:0] MR_BURST_LEN  = 3'b011,
  parameter logic       MR_BURST_SEQ  = 1'b0,
  parameter logic [2:0] MR_CAS_LAT    = 3'd3
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              sref_req_i,
  input  logic              bus_busy_i,
  output logic              bus_grant_o,
  output logic              ready_o,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic              sd_cke_o,
  output logic [ADDR_W-1:0] sd_addr_o
);

  localparam int TMAX = max_of(max_of(T_PWRUP_CYC, T_RC_CYC),
                               max_of(T_RP_CYC, T_MRD_CYC));
  localparam int TW   = $clog2(TMAX + 1);

  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_done;
  logic          due;
  logic          overrun;
  logic          refresh;
  sdr_cmd_e      cmd;

  sdr_seq_timer #(
    .W       (TW),
    .RST_VAL (TW'(T_PWRUP_CYC - 1))
  ) tmr_i (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sdr_seq_age #(
    .T_REFI_CYC    (T_REFI_CYC),
    .T_REF_MAX_CYC (T_REF_MAX_CYC)
  ) age_i (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .refresh_i (refresh),
    .sleep_i   (!sd_cke_o),
    .due_o     (due),
    .overrun_o (overrun)
  );

  sdr_seq_ctrl #(
    .T_RP_CYC     (T_RP_CYC),
    .T_RC_CYC     (T_RC_CYC),
    .T_MRD_CYC    (T_MRD_CYC),
    .N_INIT_REF   (N_INIT_REF),
    .ADDR_W       (ADDR_W),
    .TW           (TW),
    .MR_BURST_LEN (MR_BURST_LEN),
    .MR_BURST_SEQ (MR_BURST_SEQ),
    .MR_CAS_LAT   (MR_CAS_LAT)
  ) ctrl_i (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .tmr_done_i (tmr_done),
    .due_i      (due),
    .overrun_i  (overrun),
    .busy_i     (bus_busy_i),
    .sref_req_i (sref_req_i),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .refresh_o  (refresh),
    .cmd_o      (cmd),
    .cke_o      (sd_cke_o),
    .addr_o     (sd_addr_o),
    .ready_o    (ready_o),
    .grant_o    (bus_grant_o)
  );

  assign {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd;

endmodule

// File: rtl/sdr_refresh_seq_chk.sv
module sdr_refresh_seq_chk #(
  parameter int T_PWRUP_CYC = 20000,
  parameter int T_RC_CYC    = 13,
  parameter int N_INIT_REF  = 8,
  parameter int ADDR_W      = 13
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              sref_req_i,
  input logic              bus_busy_i,
  input logic              bus_grant_o,
  input logic              ready_o,
  input logic              sd_cs_n_o,
  input logic              sd_ras_n_o,
  input logic              sd_cas_n_o,
  input logic              sd_we_n_o,
  input logic              sd_cke_o,
  input logic [ADDR_W-1:0] sd_addr_o
);

  logic [3:0] pins;
  logic       is_nop;
  logic       is_ref;
  int         boot_cyc;
  int         ref_seen;
  int         since_ref;
  int         hi_cnt;

  assign pins   = {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o};
  assign is_nop = (pins == 4'b0111);
  assign is_ref = (pins == 4'b0001) && sd_cke_o;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      boot_cyc  <= 0;
      ref_seen  <= 0;
      since_ref <= 0;
      hi_cnt    <= 0;
    end else begin
      if (boot_cyc < T_PWRUP_CYC) boot_cyc <= boot_cyc + 1;
      if (is_ref && ref_seen < 1000) ref_seen <= ref_seen + 1;
      if (is_ref) since_ref <= 1;
      else if (since_ref != 0 && since_ref < 1000000) since_ref <= since_ref + 1;
      if (!sd_cke_o) hi_cnt <= 0;
      else if (hi_cnt < 1000000) hi_cnt <= hi_cnt + 1;
    end
  end

  AST_PWRUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (boot_cyc < T_PWRUP_CYC) |-> (is_nop && sd_cke_o && !ready_o && !bus_grant_o)); // R1

  AST_PREA_A10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (pins == 4'b0010) |-> sd_addr_o[10]); // R2

  AST_MRS_AFTER_BURST: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (pins == 4'b0000) |-> (ref_seen >= N_INIT_REF)); // R3

  AST_REF_SPACING: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (is_ref && since_ref != 0) |-> (since_ref >= T_RC_CYC)); // R3

  AST_GRANT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    bus_grant_o |-> (is_nop && sd_cke_o)); // R6

  AST_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    bus_busy_i |-> is_nop); // R6

  AST_SRE_ENCODE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(sd_cke_o) |-> (pins == 4'b0001)); // R8

  AST_CKE_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!sd_cke_o && sref_req_i) |=> !sd_cke_o); // R8

  AST_SRX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sd_cke_o && hi_cnt < T_RC_CYC + 2) |-> (is_nop && !ready_o)); // R9

endmodule

bind sdr_refresh_seq sdr_refresh_seq_chk #(
  .T_PWRUP_CYC (T_PWRUP_CYC),
  .T_RC_CYC    (T_RC_CYC),
  .N_INIT_REF  (N_INIT_REF),
  .ADDR_W      (ADDR_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .sref_req_i  (sref_req_i),
  .bus_busy_i  (bus_busy_i),
  .bus_grant_o (bus_grant_o),
  .ready_o     (ready_o),
  .sd_cs_n_o   (sd_cs_n_o),
  .sd_ras_n_o  (sd_ras_n_o),
  .sd_cas_n_o  (sd_cas_n_o),
  .sd_we_n_o   (sd_we_n_o),
  .sd_cke_o    (sd_cke_o),
  .sd_addr_o   (sd_addr_o)
);

// File: tb/sdr_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module sdr_refresh_seq_tb_top;

  localparam int AW = 12;

  typedef struct {
    int          cyc;
    logic [3:0]  cmd;
    logic        cke;
    logic [AW-1:0] addr;
    string       rq;
  } ev_t;

  logic          clk;
  logic          rst_n;
  logic          sref_req;
  logic          busy;
  logic          grant;
  logic          ready;
  logic          cs_n, ras_n, cas_n, we_n, cke;
  logic [AW-1:0] addr;

  int  cyc;
  int  checks;
  int  fails;
  bit  done;
  logic prev_cke;
  ev_t exp_q[$];

  sdr_refresh_seq #(
    .T_PWRUP_CYC   (60),
    .T_RP_CYC      (3),
    .T_RC_CYC      (6),
    .T_MRD_CYC     (2),
    .T_REFI_CYC    (100),
    .T_REF_MAX_CYC (160),
    .N_INIT_REF    (8),
    .ADDR_W        (AW),
    .MR_BURST_LEN  (3'b010),
    .MR_BURST_SEQ  (1'b1),
    .MR_CAS_LAT    (3'b010)
  ) dut_i (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .sref_req_i  (sref_req),
    .bus_busy_i  (busy),
    .bus_grant_o (grant),
    .ready_o     (ready),
    .sd_cs_n_o   (cs_n),
    .sd_ras_n_o  (ras_n),
    .sd_cas_n_o  (cas_n),
    .sd_we_n_o   (we_n),
    .sd_cke_o    (cke),
    .sd_addr_o   (addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Driver side of the scoreboard
  task automatic push_ev(input int c, input logic [3:0] cm, input logic ck,
                         input logic [AW-1:0] a, input string rq);
    ev_t e;
    e.cyc = c; e.cmd = cm; e.cke = ck; e.addr = a; e.rq = rq;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", rq, what, cyc, act, exp);
    end
  endtask

  // Monitor side: every non-NOP command or CKE change is an event
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111 || cke != prev_cke) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R6 unexpected event: actual cyc=%0d cmd=%b cke=%b expected none",
                   cyc, {cs_n, ras_n, cas_n, we_n}, cke);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          if (e.cyc != cyc || e.cmd != {cs_n, ras_n, cas_n, we_n} ||
              e.cke != cke || e.addr != addr) begin
            fails++;
            $display("FAIL %s event: actual cyc=%0d cmd=%b cke=%b addr=%h expected cyc=%0d cmd=%b cke=%b addr=%h",
                     e.rq, cyc, {cs_n, ras_n, cas_n, we_n}, cke, addr,
                     e.cyc, e.cmd, e.cke, e.addr);
          end
        end
      end
      prev_cke = cke;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R1 watchdog: actual cycle=%0d expected finish by 1300", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0; prev_cke = 1'b1;
    rst_n = 1'b0; sref_req = 1'b0; busy = 1'b0;

    // Expected command stream
    push_ev(60, 4'b0010, 1'b1, 12'h400, "R2");
    for (int i = 0; i < 8; i++) push_ev(63 + 6 * i, 4'b0001, 1'b1, 12'h000, "R3");
    push_ev(111, 4'b0000, 1'b1, 12'h02A, "R4");
    push_ev(207, 4'b0001, 1'b1, 12'h000, "R5");
    push_ev(309, 4'b0001, 1'b1, 12'h000, "R5");
    push_ev(431, 4'b0001, 1'b1, 12'h000, "R6");
    push_ev(721, 4'b0001, 1'b1, 12'h000, "R7");
    push_ev(727, 4'b0001, 1'b1, 12'h000, "R7");
    push_ev(829, 4'b0001, 1'b1, 12'h000, "R5");
    push_ev(852, 4'b0001, 1'b0, 12'h000, "R8");
    push_ev(901, 4'b0111, 1'b1, 12'h000, "R9");
    push_ev(1003, 4'b0001, 1'b1, 12'h000, "R9");
    push_ev(1111, 4'b0001, 1'b1, 12'h000, "R10");
    push_ev(1119, 4'b0001, 1'b0, 12'h000, "R10");
    push_ev(1151, 4'b0111, 1'b1, 12'h000, "R9");
    push_ev(1253, 4'b0001, 1'b1, 12'h000, "R5");

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset / power-up quiet
    wait_cyc(0);
    chk("R1", "cke", cke, 1'b1);
    chk("R1", "nop", ({cs_n, ras_n, cas_n, we_n} == 4'b0111), 1'b1);
    chk("R1", "ready", ready, 1'b0);
    chk("R1", "grant", grant, 1'b0);
    wait_cyc(59);
    chk("R1", "ready late", ready, 1'b0);
    // R4 ready after mode load
    wait_cyc(112);
    chk("R4", "ready before tMRD", ready, 1'b0);
    wait_cyc(113);
    chk("R4", "ready", ready, 1'b1);
    chk("R4", "grant", grant, 1'b1);
    // R5 periodic refresh drops ready
    wait_cyc(207);
    chk("R5", "ready in refresh", ready, 1'b0);
    chk("R5", "grant in refresh", grant, 1'b0);
    wait_cyc(213);
    chk("R5", "ready after refresh", ready, 1'b1);
    // R6 short busy hold
    wait_cyc(380);
    busy = 1'b1;
    wait_cyc(410);
    chk("R6", "grant withdrawn", grant, 1'b0);
    chk("R6", "ready while draining", ready, 1'b1);
    wait_cyc(425);
    chk("R6", "grant still withdrawn", grant, 1'b0);
    wait_cyc(430);
    busy = 1'b0;
    // R7 long busy hold -> two refreshes
    wait_cyc(520);
    busy = 1'b1;
    wait_cyc(720);
    busy = 1'b0;
    wait_cyc(732);
    chk("R7", "ready after first of pair", ready, 1'b0);
    wait_cyc(733);
    chk("R7", "ready after pair", ready, 1'b1);
    // R8 / R9 self refresh from idle
    wait_cyc(850);
    sref_req = 1'b1;
    wait_cyc(880);
    chk("R8", "cke held low", cke, 1'b0);
    chk("R8", "ready in self refresh", ready, 1'b0);
    wait_cyc(900);
    sref_req = 1'b0;
    wait_cyc(908);
    chk("R9", "ready in exit window", ready, 1'b0);
    wait_cyc(909);
    chk("R9", "ready after exit", ready, 1'b1);
    // R10 refresh and self refresh pending together
    wait_cyc(1090);
    sref_req = 1'b1;
    busy = 1'b1;
    wait_cyc(1095);
    chk("R10", "grant withdrawn", grant, 1'b0);
    wait_cyc(1110);
    busy = 1'b0;
    wait_cyc(1150);
    sref_req = 1'b0;
    wait_cyc(1158);
    chk("R9", "ready in second exit window", ready, 1'b0);
    wait_cyc(1159);
    chk("R9", "ready after second exit", ready, 1'b1);
    wait_cyc(1270);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5 missing events: actual pending=%0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule